// File: doc/BRIEF.md
# Framed Test Packet Checker

This block sits on the receive side of a serial test link and watches a stream of 20-bit words produced by a framed pattern generator. Each packet opens with a start control word, carries a fixed number of data words, and closes with an end control word. Every data word holds a 16-bit payload in its low bits and four parity bits in its top four bits, one parity bit for each payload nibble.

The checker runs three tests on every data word at the same time. It compares the payload with its own copy of the circular pattern register, which is seeded from the pattern select input at every start word. It recomputes the four nibble parity bits. It counts the data words in the packet. Each failed test sets its own bit in a 4-bit error code. A fourth bit flags framing trouble: a data word outside a packet, a start word inside a packet, an end word outside a packet, or a control word it does not recognise. When any bit is set, the block raises a one-cycle strobe and presents the code together with the offending word, so that a logger downstream can record both.

Top module: `chk_pkt_checker`

## Requirements
- R1: A data word is `{par[3:0], data[15:0]}`. Parity bit i must equal the XOR of `data[4i+3:4i]`, so each 5-bit group has even parity. Any mismatch sets error code bit 1. This check applies to data words inside and outside a packet.
- R2: A word with `rx_ctrl`=1 is a control word. Low bits `2'b01` mean start and `2'b10` mean end. Any other control word sets error code bit 3 and leaves the packet state unchanged.
- R3: Inside a packet, the payload of the k-th data word (counting from k=0) must equal the seed rotated left by k bits. The seed is picked by `pat_sel` when the start word arrives: 0 gives 16'h0001, 1 gives 16'hFFFE, 2 gives 16'hAAAA, 3 gives 16'h00FF. A payload mismatch sets error code bit 0.
- R4: A packet must hold exactly 224 data words. An end word that arrives after fewer words sets error code bit 2 on that end word. The 225th data word sets bit 2 on itself. Further data words and the closing end word of that packet do not set bit 2 again.
- R5: A data word outside a packet, a start word inside a packet, and an end word outside a packet each set error code bit 3. A data word outside a packet is not compared with the pattern. A start word inside a packet abandons the open packet and opens a new one.
- R6: The expected pattern depends only on the seed and the position of the word in the packet, and it is reloaded at every start word. A corrupted data word therefore affects no other word.
- R7: One cycle after an erroneous input word, `err_valid` is high for exactly one cycle. In that cycle `err_code` carries every error bit that applies to the word, which can be more than one, and `err_word` equals the word. In every other cycle `err_valid` is 0 and `err_code` is 0.
- R8: While reset is held, and just after it is released, `err_valid` is 0, `err_code` is 0, `err_word` is 0, and the checker is outside any packet.
- R9: A cycle with `rx_valid`=0 is ignored. It produces no error and does not advance the word count or the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received word is present this cycle |
| rx_ctrl | input | 1 | Received word is a control word |
| rx_word | input | 20 | Received word: parity nibble over 16-bit payload |
| pat_sel | input | 2 | Pattern selection, sampled at each start word |
| err_valid | output | 1 | One-cycle strobe for an erroneous word |
| err_code | output | 4 | Bit 0 data, bit 1 parity, bit 2 length, bit 3 framing |
| err_word | output | 20 | Copy of the erroneous word |

## Verification
The assertions assume that `rx_valid` is held low throughout reset, so that the first sampled history after reset contains no word. They also assume that `rx_word` and `rx_ctrl` are stable for the whole cycle in which they are sampled. The stimulus drives every input one time unit after a rising edge and keeps `rx_valid` low during reset. Each packet is built from the requirement's seed and rotation rules, with deliberate corruption only at the listed positions, so each error the bench expects comes from a single known cause or a known combination of causes.

// File: rtl/chk_pkg.sv
package chk_pkg;

    typedef enum logic [1:0] {
        PAT_WALK1  = 2'd0,
        PAT_WALK0  = 2'd1,
        PAT_ALT    = 2'd2,
        PAT_WALKFF = 2'd3
    } pat_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PKT  = 1'b1
    } st_e;

    // low two bits of a control word
    localparam logic [1:0] CW_START = 2'b01;
    localparam logic [1:0] CW_END   = 2'b10;

    // error code: bit 3 framing, bit 2 length, bit 1 parity, bit 0 data
    typedef struct packed {
        logic ctl_err;
        logic len_err;
        logic par_err;
        logic dat_err;
    } code_t;

endpackage

// File: rtl/chk_patgen.sv
module chk_patgen
    import chk_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  pat_e              sel,
    output logic [DATA_W-1:0] expect_o
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] seed;
    logic [DATA_W-1:0] pat_q;

    always_comb begin
        case (sel)
            PAT_WALK1:  seed = DATA_W'(1);
            PAT_WALK0:  seed = ~DATA_W'(1);
            PAT_ALT:    seed = {HALF{2'b10}};
            default:    seed = {{HALF{1'b0}}, {HALF{1'b1}}};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= '0;
        end else if (load) begin
            pat_q <= seed;
        end else if (adv) begin
            pat_q <= {pat_q[DATA_W-2:0], pat_q[DATA_W-1]};
        end
    end

    assign expect_o = pat_q;

endmodule

// File: rtl/chk_parity.sv
module chk_parity #(
    parameter int DATA_W = 16,
    parameter int NIB_W  = 4,
    localparam int PAR_W = DATA_W / NIB_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic [PAR_W-1:0]  par_in,
    output logic              err_o
);
    logic [PAR_W-1:0] calc;

    for (genvar i = 0; i < PAR_W; i++) begin : g_nib
        assign calc[i] = ^data[i*NIB_W +: NIB_W];
    end

    assign err_o = |(calc ^ par_in);

endmodule

// File: rtl/chk_pkt_checker.sv
module chk_pkt_checker
    import chk_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NIB_W   = 4,
    parameter int PKT_LEN = 224,
    localparam int PAR_W  = DATA_W / NIB_W,
    localparam int WORD_W = DATA_W + PAR_W,
    localparam int CNT_W  = $clog2(PKT_LEN + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              rx_ctrl,
    input  logic [WORD_W-1:0] rx_word,
    input  logic [1:0]        pat_sel,
    output logic              err_valid,
    output logic [3:0]        err_code,
    output logic [WORD_W-1:0] err_word
);
    localparam logic [CNT_W-1:0] LEN_OK   = CNT_W'(PKT_LEN);
    localparam logic [CNT_W-1:0] LEN_OVER = CNT_W'(PKT_LEN + 1);

    st_e               st;
    logic [CNT_W-1:0]  pkt_cnt;
    logic [DATA_W-1:0] exp_data;
    logic              par_bad;
    logic              is_data, is_start, is_end, is_badctl;
    logic              in_pkt;
    code_t             code;

    assign in_pkt    = (st == ST_PKT);
    assign is_data   = rx_valid && !rx_ctrl;
    assign is_start  = rx_valid && rx_ctrl && (rx_word[1:0] == CW_START);
    assign is_end    = rx_valid && rx_ctrl && (rx_word[1:0] == CW_END);
    assign is_badctl = rx_valid && rx_ctrl && !is_start && !is_end;

    chk_patgen #(.DATA_W(DATA_W)) u_pat (
        .clk      (clk),
        .rst      (rst),
        .load     (is_start),
        .adv      (is_data && in_pkt),
        .sel      (pat_e'(pat_sel)),
        .expect_o (exp_data)
    );

    chk_parity #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_par (
        .data   (rx_word[DATA_W-1:0]),
        .par_in (rx_word[WORD_W-1:DATA_W]),
        .err_o  (par_bad)
    );

    always_comb begin
        code = '0;
        if (is_data) begin
            code.par_err = par_bad;
            if (in_pkt) begin
                code.dat_err = (rx_word[DATA_W-1:0] != exp_data);
                code.len_err = (pkt_cnt == LEN_OK);
            end else begin
                code.ctl_err = 1'b1;
            end
        end
        if (is_start && in_pkt) begin
            code.ctl_err = 1'b1;
        end
        if (is_end) begin
            if (in_pkt) begin
                code.len_err = (pkt_cnt < LEN_OK);
            end else begin
                code.ctl_err = 1'b1;
            end
        end
        if (is_badctl) begin
            code.ctl_err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            pkt_cnt <= '0;
        end else if (is_start) begin
            st      <= ST_PKT;
            pkt_cnt <= '0;
        end else if (is_end) begin
            st      <= ST_IDLE;
        end else if (is_data && in_pkt && (pkt_cnt != LEN_OVER)) begin
            pkt_cnt <= pkt_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_valid <= 1'b0;
            err_code  <= '0;
            err_word  <= '0;
        end else begin
            err_valid <= |code;
            err_code  <= code;
            if (|code) begin
                err_word <= rx_word;
            end
        end
    end

endmodule

module chk_pkt_checker_sva #(
    parameter int WORD_W  = 20,
    parameter int CNT_W   = 8,
    parameter int PKT_LEN = 224
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic              rx_ctrl,
    input logic [WORD_W-1:0] rx_word,
    input logic              err_valid,
    input logic [3:0]        err_code,
    input logic [WORD_W-1:0] err_word,
    input logic [CNT_W-1:0]  cnt
);
    a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!err_valid && err_code == 4'd0));

    a_r7_code_zero_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !err_valid |-> (err_code == 4'd0));

    a_r7_strobe_has_cause: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (err_code != 4'd0));

    a_r7_word_captured: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (err_word == $past(rx_word)));

    a_r9_idle_cycle_silent: assert property (@(posedge clk) disable iff (rst)
        !$past(rx_valid) |-> !err_valid);

    a_r1_parity_from_data_word: assert property (@(posedge clk) disable iff (rst)
        err_code[1] |-> !$past(rx_ctrl));

    a_r3_compare_from_data_word: assert property (@(posedge clk) disable iff (rst)
        err_code[0] |-> !$past(rx_ctrl));

    a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(PKT_LEN + 1));

endmodule

bind chk_pkt_checker chk_pkt_checker_sva #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W),
    .PKT_LEN(PKT_LEN)
) u_sva (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_ctrl  (rx_ctrl),
    .rx_word  (rx_word),
    .err_valid(err_valid),
    .err_code (err_code),
    .err_word (err_word),
    .cnt      (pkt_cnt)
);

// File: tb/chk_pkt_checker_tb.sv
module chk_pkt_checker_tb;

    localparam int LEN = 224;
    localparam logic [19:0] W_START = 20'h00001;
    localparam logic [19:0] W_END   = 20'h00002;
    localparam logic [19:0] W_BADC  = 20'h00003;

    typedef struct {
        logic [3:0]  code;
        logic [19:0] word;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic        rx_ctrl = 1'b0;
    logic [19:0] rx_word = '0;
    logic [1:0]  pat_sel = '0;
    logic        err_valid;
    logic [3:0]  err_code;
    logic [19:0] err_word;

    int n_chk = 0;
    int n_bad = 0;
    item_t q[$];

    always #10 clk = ~clk;

    chk_pkt_checker u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ctrl(rx_ctrl),
        .rx_word(rx_word), .pat_sel(pat_sel), .err_valid(err_valid),
        .err_code(err_code), .err_word(err_word)
    );

    function automatic logic [15:0] pat_at(input logic [1:0] sel, input int k);
        logic [15:0] p;
        case (sel)
            2'd0: p = 16'h0001;
            2'd1: p = 16'hFFFE;
            2'd2: p = 16'hAAAA;
            default: p = 16'h00FF;
        endcase
        for (int i = 0; i < (k % 16); i++) p = {p[14:0], p[15]};
        return p;
    endfunction

    function automatic logic [19:0] mkw(input logic [15:0] d);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ^d[i*4 +: 4];
        return {p, d};
    endfunction

    task automatic put(input logic c, input logic [19:0] w);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_ctrl = c; rx_word = w;
    endtask

    task automatic idle(input int n);
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_ctrl = 1'b1; rx_word = 20'hFFFFF;
        repeat (n - 1) @(posedge clk);
    endtask

    task automatic expect_err(input logic [3:0] c, input logic [19:0] w, input string tag);
        item_t it;
        it.code = c; it.word = w; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic drained(input string tag);
        idle(3);
        n_chk++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL %s: %0d expected errors missing, expected 0", tag, q.size());
            q.delete();
        end
    endtask

    // monitor: pop and compare
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && err_valid) begin
                n_chk++;
                if (q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R7 unexpected error: code=%b word=%h, expected none",
                             err_code, err_word);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    if (err_code !== it.code || err_word !== it.word) begin
                        n_bad++;
                        $display("FAIL %s: code=%b word=%h, expected code=%b word=%h",
                                 it.tag, err_code, err_word, it.code, it.word);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (4) @(posedge clk);
        #1;
        n_chk++;
        if (err_valid !== 1'b0 || err_code !== 4'd0 || err_word !== 20'd0) begin
            n_bad++;
            $display("FAIL R8 reset state: v=%b code=%b word=%h, expected 0 0 0",
                     err_valid, err_code, err_word);
        end
        rst = 1'b0;
        idle(2);
        n_chk++;
        if (err_valid !== 1'b0 || err_code !== 4'd0) begin
            n_bad++;
            $display("FAIL R8 after release: v=%b code=%b, expected 0 0", err_valid, err_code);
        end

        // R3 R4: clean packet, walking one
        pat_sel = 2'd0;
        put(1'b1, W_START);
        for (int k = 0; k < LEN; k++) put(1'b0, mkw(pat_at(2'd0, k)));
        put(1'b1, W_END);
        drained("R3 clean packet sel0");

        // R3 R1 R7 R6: corruptions in walking zero packet
        pat_sel = 2'd1;
        put(1'b1, W_START);
        for (int k = 0; k < LEN; k++) begin
            d = pat_at(2'd1, k);
            if (k == 5) begin
                expect_err(4'b0001, mkw(d ^ 16'h0100), "R3 data mismatch");
                put(1'b0, mkw(d ^ 16'h0100));
            end else if (k == 10) begin
                expect_err(4'b0010, mkw(d) ^ 20'h10000, "R1 parity error");
                put(1'b0, mkw(d) ^ 20'h10000);
            end else if (k == 20) begin
                expect_err(4'b0011, {mkw(d)[19:16], d ^ 16'h0001}, "R7 combined data+parity");
                put(1'b0, {mkw(d)[19:16], d ^ 16'h0001});
            end else begin
                put(1'b0, mkw(d));
            end
        end
        put(1'b1, W_END);
        drained("R6 later words clean after corruption");

        // R4 short packet, alternating
        pat_sel = 2'd2;
        put(1'b1, W_START);
        for (int k = 0; k < 100; k++) put(1'b0, mkw(pat_at(2'd2, k)));
        expect_err(4'b0100, W_END, "R4 short packet");
        put(1'b1, W_END);
        drained("R4 short packet");

        // R4 overrun, walking FF
        pat_sel = 2'd3;
        put(1'b1, W_START);
        for (int k = 0; k < LEN + 2; k++) begin
            if (k == LEN) expect_err(4'b0100, mkw(pat_at(2'd3, k)), "R4 225th word");
            put(1'b0, mkw(pat_at(2'd3, k)));
        end
        put(1'b1, W_END);
        drained("R4 overrun reported once");

        // R5 R2 framing outside a packet
        expect_err(4'b1000, mkw(16'h1234), "R5 data outside packet");
        put(1'b0, mkw(16'h1234));
        expect_err(4'b1010, mkw(16'h1234) ^ 20'h80000, "R5 R1 outside with bad parity");
        put(1'b0, mkw(16'h1234) ^ 20'h80000);
        expect_err(4'b1000, W_END, "R5 end outside packet");
        put(1'b1, W_END);
        expect_err(4'b1000, W_BADC, "R2 unknown control outside");
        put(1'b1, W_BADC);
        drained("R5 framing outside");

        // R2 R5 R6 R9 inside a packet
        pat_sel = 2'd0;
        put(1'b1, W_START);
        for (int k = 0; k < 50; k++) put(1'b0, mkw(pat_at(2'd0, k)));
        expect_err(4'b1000, W_BADC, "R2 unknown control inside");
        put(1'b1, W_BADC);
        for (int k = 50; k < 60; k++) put(1'b0, mkw(pat_at(2'd0, k)));
        pat_sel = 2'd1;
        expect_err(4'b1000, W_START, "R5 start inside packet");
        put(1'b1, W_START);
        for (int k = 0; k < LEN; k++) begin
            put(1'b0, mkw(pat_at(2'd1, k)));
            if (k % 37 == 3) idle(2);
        end
        put(1'b1, W_END);
        drained("R9 R6 restarted packet with gaps clean");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule